// File: doc/BRIEF.md
# Byte Program Retry Sequencer

This block writes a whole byte-wide, electrically programmable memory from a data source. It fetches the wanted value for each location through a request/valid handshake. It then drives the location with repeated timed program pulses at the high programming supply. After every pulse it reads the byte back. When the byte matches, it moves to the next location. If a location still reads wrong after the allowed number of pulses, the sequence stops and reports failure.

Once the last location has passed its own check, the sequencer drops the supply back to the normal level. It fetches every source byte again in address order and compares each one with a plain read of the array. A single mismatch stops the run with a fail result. A clean pass through all locations gives a pass result.

All memory-side timing is counted in clock cycles: setup, pulse width, data hold, read access and bus float. A host pulses `start` and then waits for `done`. The `pass` output holds the verdict until the next start.

Top module: `bprog_seq`

## Requirements
- R1: Out of reset, and while idle, the memory controls are inactive: chip select high, read enable high, write driver off, supply at normal level, and `busy`, `done` and `src_req` low. A start raises `src_req` for address 0, with the supply select at programming level.
- R2: Each program pulse holds `mem_ce_n` low for exactly `T_PULSE` cycles, with `mem_vpp_hi` high and `mem_oe_n` high throughout.
- R3: Before each pulse, address, write data, driver enable and supply are steady, with the driver on, for at least `T_SETUP` cycles. After the pulse, the write data stays driven for at least `T_HOLD` cycles. Address and data do not move during the pulse.
- R4: Each check after a pulse is done at programming supply with `mem_ce_n` high and `mem_oe_n` low. The read byte is taken in the last of `T_READ` cycles and compared with the wanted byte.
- R5: A location gets at most `MAX_TRIES` pulses. A mismatch after pulse number `MAX_TRIES` ends the run with `done`=1 and `pass`=0, and no further pulse is applied. A match on that same last pulse counts as success.
- R6: A match moves to the next address, and that address gets a fresh count of `MAX_TRIES` attempts.
- R7: The write driver is off for at least one cycle before `mem_oe_n` falls. It is never on while `mem_oe_n` is low. `mem_oe_n` stays high for at least `T_FLOAT` cycles before the driver turns on again.
- R8: After the last address matches, `mem_vpp_hi` goes low. Each address from 0 upward is re-fetched from the source and read with `mem_ce_n` and `mem_oe_n` both low. The first mismatch ends the run with `pass`=0. If all addresses match, the run ends with `pass`=1.
- R9: While `src_req` is high and `src_valid` is low, the sequencer waits: `src_req` and `src_addr` hold, and no memory operation starts.
- R10: `done` and `pass` hold until the next `start`. A `start` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a full program-and-compare run (one-cycle pulse) |
| src_req | output | 1 | Request for the source byte at `src_addr` |
| src_addr | output | ADDR_W | Address of the requested source byte |
| src_valid | input | 1 | Source byte on `src_data` is valid |
| src_data | input | DATA_W | Wanted byte for `src_addr` |
| mem_vpp_hi | output | 1 | 1 selects the programming supply, 0 the normal supply |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data to the memory data pins |
| mem_wdata_oe | output | 1 | Enable of the write data driver |
| mem_ce_n | output | 1 | Chip enable, active low (program pulse or read) |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_rdata | input | DATA_W | Data read from the memory pins |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; `pass` is valid |
| pass | output | 1 | Verdict of the last run |

## Verification
The attempt limit and a successful check can meet in the same decision cycle. This happens when a byte takes exactly `MAX_TRIES` pulses to settle. The memory model in the bench lets one address need exactly that many pulses, and in another run one pulse more. The first run must continue and finish with pass, using exactly the computed pulse count. The second must stop on that address with fail and never reach the final compare. A second coincidence is the last address matching at the moment the supply switches for the final compare. A marginal cell that reads correctly only at programming supply checks that the final compare is separate from the per-byte check.

// File: rtl/bprog_pkg.sv
// Package: shared state encoding for the byte program sequencer.
package bprog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_RELEASE,
        ST_VERIFY,
        ST_FLOAT,
        ST_FIN_FETCH,
        ST_FIN_READ,
        ST_FIN_GAP,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/bprog_timer.sv
// bprog_timer: shared phase timer. Loading N-1 makes the timer reach zero
// after N cycles. Assumes the sequencer loads it on every timed state entry.
module bprog_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Count down from the loaded value and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // The phase length depends on a clean one-per-cycle step (R2).
    assert_timer_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/bprog_track.sv
// bprog_track: current address and per-address pulse attempt count.
// Assumes clear, bump, advance and rewind are never raised together.
module bprog_track #(
    parameter int ADDR_W    = 15,
    parameter int MAX_TRIES = 25,
    parameter int TRY_W     = $clog2(MAX_TRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bump,
    input  logic              advance,
    input  logic              rewind,
    output logic [ADDR_W-1:0] addr,
    output logic [TRY_W-1:0]  tries,
    output logic              last_addr,
    output logic              at_limit
);

    // Address register: cleared on start and before the final compare, stepped on success.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || rewind) addr <= '0;
        else if (advance)            addr <= addr + 1'b1;
    end

    // Attempt counter: one per pulse, fresh on every new address.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || rewind || advance) tries <= '0;
        else if (bump)                          tries <= tries + 1'b1;
    end

    assign last_addr = (addr == {ADDR_W{1'b1}});
    assign at_limit  = (tries == TRY_W'(MAX_TRIES));

    assert_tries_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tries <= TRY_W'(MAX_TRIES));

    assert_fresh_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr) |-> (tries == '0));

endmodule

// File: rtl/bprog_seq.sv
// bprog_seq: programs every byte of the memory with timed pulses, checks
// each byte after every pulse, gives up after MAX_TRIES pulses, then compares
// the whole array with the source at normal supply. All timing parameters
// are in clock cycles and must be at least 1.
module bprog_seq
    import bprog_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int MAX_TRIES = 25,
    parameter int T_SETUP   = 100,
    parameter int T_PULSE   = 5000,
    parameter int T_HOLD    = 100,
    parameter int T_READ    = 8,
    parameter int T_FLOAT   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              src_req,
    output logic [ADDR_W-1:0] src_addr,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              mem_vpp_hi,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_oe,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              pass
);

    localparam int LONG_A  = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
    localparam int LONG_B  = (T_HOLD > T_READ) ? T_HOLD : T_READ;
    localparam int LONG_C  = (LONG_A > LONG_B) ? LONG_A : LONG_B;
    localparam int LONGEST = (LONG_C > T_FLOAT) ? LONG_C : T_FLOAT;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam int TRY_W   = $clog2(MAX_TRIES + 1);

    seq_state_e        state_q, state_d;
    logic [DATA_W-1:0] want_q, got_q;
    logic              pass_q, pass_d, pass_ld;
    logic              want_ld, got_ld;
    logic              trk_clr, trk_bump, trk_adv, trk_rew;
    logic [ADDR_W-1:0] addr;
    logic [TRY_W-1:0]  tries;
    logic              last_addr, at_limit;
    logic              tmr_load, tmr_zero;
    logic [CNT_W-1:0]  tmr_val;

    bprog_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    bprog_track #(.ADDR_W(ADDR_W), .MAX_TRIES(MAX_TRIES), .TRY_W(TRY_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (trk_clr),
        .bump      (trk_bump),
        .advance   (trk_adv),
        .rewind    (trk_rew),
        .addr      (addr),
        .tries     (tries),
        .last_addr (last_addr),
        .at_limit  (at_limit)
    );

    // Next-state and control pulses of the sequencer.
    always_comb begin
        state_d  = state_q;
        trk_clr  = 1'b0;
        trk_bump = 1'b0;
        trk_adv  = 1'b0;
        trk_rew  = 1'b0;
        want_ld  = 1'b0;
        got_ld   = 1'b0;
        pass_ld  = 1'b0;
        pass_d   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_d = ST_FETCH;
                    trk_clr = 1'b1;
                end
            end
            ST_FETCH: begin
                if (src_valid) begin
                    want_ld = 1'b1;
                    state_d = ST_SETUP;
                end
            end
            ST_SETUP:   if (tmr_zero) state_d = ST_PULSE;
            ST_PULSE: begin
                if (tmr_zero) begin
                    trk_bump = 1'b1;
                    state_d  = ST_HOLD;
                end
            end
            ST_HOLD:    if (tmr_zero) state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_VERIFY;
            ST_VERIFY: begin
                if (tmr_zero) begin
                    got_ld  = 1'b1;
                    state_d = ST_FLOAT;
                end
            end
            ST_FLOAT: begin
                if (tmr_zero) begin
                    if (got_q == want_q) begin
                        if (last_addr) begin
                            trk_rew = 1'b1;
                            state_d = ST_FIN_FETCH;
                        end else begin
                            trk_adv = 1'b1;
                            state_d = ST_FETCH;
                        end
                    end else if (at_limit) begin
                        pass_ld = 1'b1;
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_SETUP;
                    end
                end
            end
            ST_FIN_FETCH: begin
                if (src_valid) begin
                    want_ld = 1'b1;
                    state_d = ST_FIN_READ;
                end
            end
            ST_FIN_READ: begin
                if (tmr_zero) begin
                    got_ld  = 1'b1;
                    state_d = ST_FIN_GAP;
                end
            end
            ST_FIN_GAP: begin
                if (tmr_zero) begin
                    if (got_q != want_q) begin
                        pass_ld = 1'b1;
                        state_d = ST_DONE;
                    end else if (last_addr) begin
                        pass_ld = 1'b1;
                        pass_d  = 1'b1;
                        state_d = ST_DONE;
                    end else begin
                        trk_adv = 1'b1;
                        state_d = ST_FIN_FETCH;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase length chosen by the state being entered.
    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_SETUP:                tmr_val = CNT_W'(T_SETUP - 1);
            ST_PULSE:                tmr_val = CNT_W'(T_PULSE - 1);
            ST_HOLD:                 tmr_val = CNT_W'(T_HOLD - 1);
            ST_VERIFY, ST_FIN_READ:  tmr_val = CNT_W'(T_READ - 1);
            ST_FLOAT, ST_FIN_GAP:    tmr_val = CNT_W'(T_FLOAT - 1);
            default:                 tmr_val = '0;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Wanted byte from the source and byte read back from the memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_q <= '0;
            got_q  <= '0;
        end else begin
            if (want_ld) want_q <= src_data;
            if (got_ld)  got_q  <= mem_rdata;
        end
    end

    // Verdict register: cleared on start, written when the run ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pass_q <= 1'b0;
        else if (trk_clr)             pass_q <= 1'b0;
        else if (pass_ld)             pass_q <= pass_d;
    end

    // Memory pin controls decoded from the state.
    always_comb begin
        mem_vpp_hi   = state_q inside {ST_FETCH, ST_SETUP, ST_PULSE, ST_HOLD,
                                       ST_RELEASE, ST_VERIFY, ST_FLOAT};
        mem_wdata_oe = state_q inside {ST_SETUP, ST_PULSE, ST_HOLD};
        mem_ce_n     = !(state_q inside {ST_PULSE, ST_FIN_READ});
        mem_oe_n     = !(state_q inside {ST_VERIFY, ST_FIN_READ});
    end

    assign mem_addr  = addr;
    assign mem_wdata = want_q;
    assign src_addr  = addr;
    assign src_req   = (state_q == ST_FETCH) || (state_q == ST_FIN_FETCH);
    assign busy      = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign done      = (state_q == ST_DONE);
    assign pass      = pass_q;

    // Checker: length of the current chip-enable low run.
    logic [CNT_W:0] chk_ce_run;
    always_ff @(posedge clk) begin
        if (!rst_n)        chk_ce_run <= '0;
        else if (!mem_ce_n) chk_ce_run <= chk_ce_run + 1'b1;
        else               chk_ce_run <= '0;
    end

    assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_ce_n) && mem_vpp_hi) |-> (chk_ce_run == (CNT_W+1)'(T_PULSE)));

    assert_oe_high_in_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && mem_vpp_hi) |-> mem_oe_n);

    assert_pulse_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n) && mem_vpp_hi) |-> ($stable(mem_addr) && $stable(mem_wdata)));

    assert_verify_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && mem_vpp_hi) |-> mem_ce_n);

    assert_no_fight_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_wdata_oe);

    assert_release_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_wdata_oe));

    assert_final_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && !mem_vpp_hi) |-> !mem_ce_n);

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req && !src_valid) |=> (src_req && $stable(src_addr)));

    assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass)));

endmodule

// File: tb/bprog_seq_tb.sv
// bprog_seq_tb: memory and source models, a table of runs, directed checks.
module bprog_seq_tb;

    localparam int AW = 3;
    localparam int DW = 8;
    localparam int NA = 1 << AW;
    localparam int MT = 25;
    localparam int TS = 3;
    localparam int TP = 5;
    localparam int TH = 2;
    localparam int TR = 2;
    localparam int TF = 2;

    typedef struct packed {
        int need;      // pulses every address needs
        int hard_a;    // address with its own need (-1 none)
        int hard_n;
        int flip_a;    // marginal address failing at normal supply (-1 none)
        int stall;     // source wait cycles per fetch
        int exp_pass;
        int exp_pulses;
        int exp_fin;
        int exp_stall;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1,  -1,  0, -1, 0, 1,   8, 8,   0},
        '{1,   3, 25, -1, 0, 1,  32, 8,   0},
        '{1,   5, 26, -1, 0, 0,  30, 0,   0},
        '{3,  -1,  0,  6, 4, 0,  24, 7,  60},
        '{2,  -1,  0, -1, 7, 1,  16, 8, 112},
        '{20, -1,  0, -1, 0, 1, 160, 8,   0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          src_req, src_valid = 1'b0;
    logic [AW-1:0] src_addr, mem_addr;
    logic [DW-1:0] src_data = '0, mem_wdata, mem_rdata;
    logic          mem_vpp_hi, mem_wdata_oe, mem_ce_n, mem_oe_n;
    logic          busy, done, pass;

    int total = 0, bad = 0, cyc = 0, cur = 0;
    logic [DW-1:0] memv [NA];
    int got [NA];
    int need [NA];
    int flip_a = -1, stall = 0, wait_c = 0;
    int pulses, fin_cnt, stalls, v2, v3, v4, v7, v8;
    int pulse_run, setup_run, hold_run, oe_hi_run;
    logic in_hold;
    logic p_ce, p_oe, p_wdoe, p_vpp;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_wdata;

    always #10 clk = ~clk;

    bprog_seq #(.ADDR_W(AW), .DATA_W(DW), .MAX_TRIES(MT), .T_SETUP(TS),
                .T_PULSE(TP), .T_HOLD(TH), .T_READ(TR), .T_FLOAT(TF)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_req(src_req), .src_addr(src_addr),
        .src_valid(src_valid), .src_data(src_data), .mem_vpp_hi(mem_vpp_hi),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .pass(pass)
    );

    function automatic logic [DW-1:0] srcd(int a);
        logic [6:0] v = 7'(a * 37 + cur * 11 + 5);
        return {1'b0, v};
    endfunction

    // Memory read model: a marginal cell only fails at normal supply.
    assign mem_rdata = !mem_oe_n ? (mem_vpp_hi ? memv[mem_addr]
                         : memv[mem_addr] ^ ((int'(mem_addr) == flip_a) ? 8'h01 : 8'h00)) : 8'h00;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Source model with a programmable wait per fetch.
    always @(negedge clk) begin
        if (!src_req) begin
            src_valid = 1'b0;
            wait_c = 0;
        end else if (!src_valid) begin
            if (wait_c == stall) begin
                src_valid = 1'b1;
                src_data = srcd(int'(src_addr));
            end else begin
                wait_c++;
                stalls++;
            end
        end
    end

    // Pin monitor: memory cell update and timing rule counters.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n && mem_vpp_hi) begin
                pulse_run++;
                if (!mem_oe_n) v2++;
                if (!p_ce && (mem_addr != p_addr || mem_wdata != p_wdata)) v3++;
            end
            if (!mem_ce_n && p_ce && mem_vpp_hi && setup_run < TS) v3++;
            if (mem_ce_n && !p_ce && p_vpp) begin
                if (pulse_run != TP) v2++;
                pulse_run = 0;
                pulses++;
                got[p_addr]++;
                if (got[p_addr] >= need[p_addr]) memv[p_addr] = memv[p_addr] & p_wdata;
            end
            if (!mem_wdata_oe && p_wdoe && in_hold) begin
                if (hold_run < TH) v3++;
                in_hold = 1'b0;
            end
            if (mem_ce_n && !p_ce && mem_vpp_hi) begin
                in_hold = 1'b1;
                hold_run = 1;
            end else if (in_hold && mem_wdata_oe) hold_run++;
            if (!mem_wdata_oe || !mem_vpp_hi) setup_run = 0;
            else if (mem_ce_n)
                setup_run = (mem_addr != p_addr || mem_wdata != p_wdata || !p_wdoe || !p_vpp)
                            ? 1 : setup_run + 1;
            if (!mem_oe_n && mem_vpp_hi && !mem_ce_n) v4++;
            if (!mem_oe_n && (mem_wdata_oe || p_wdoe)) v7++;
            if (mem_wdata_oe && !p_wdoe && oe_hi_run < TF) v7++;
            oe_hi_run = mem_oe_n ? oe_hi_run + 1 : 0;
            if (!mem_oe_n && !mem_vpp_hi) begin
                if (mem_ce_n) v8++;
                if (p_oe) begin
                    if (int'(mem_addr) != fin_cnt) v8++;
                    fin_cnt++;
                end
            end
        end
        p_ce = mem_ce_n; p_oe = mem_oe_n; p_wdoe = mem_wdata_oe; p_vpp = mem_vpp_hi;
        p_addr = mem_addr; p_wdata = mem_wdata;
    end

    // Global watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_vec(input int i);
        vec_t v = VEC[i];
        bit fin;
        cur = i;
        stall = v.stall;
        flip_a = v.flip_a;
        for (int a = 0; a < NA; a++) begin
            memv[a] = 8'hFF;
            got[a] = 0;
            need[a] = (a == v.hard_a) ? v.hard_n : v.need;
        end
        pulses = 0; fin_cnt = 0; stalls = 0;
        v2 = 0; v3 = 0; v4 = 0; v7 = 0; v8 = 0;
        pulse_run = 0; setup_run = 0; hold_run = 0; oe_hi_run = 1000; in_hold = 1'b0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (i == 0) // R1: first request is address 0 at programming supply
            check(src_req && src_addr == 0 && mem_vpp_hi, "R1 first fetch",
                  int'(src_addr), 0);
        fin = 1'b0;
        for (int c = 0; c < 20000 && !fin; c++) begin
            @(negedge clk);
            if (i == 4 && c == 300) begin
                check(busy, "R10 busy before restart attempt", int'(busy), 1);
                start = 1'b1;
                @(negedge clk) start = 1'b0;
            end
            fin = done;
        end
        check(fin, "R10 done reached", int'(fin), 1);
        check(pass == v.exp_pass[0], "R5 R8 verdict", int'(pass), v.exp_pass);
        check(pulses == v.exp_pulses, "R5 R6 pulse count", pulses, v.exp_pulses);
        check(fin_cnt == v.exp_fin, "R8 final reads", fin_cnt, v.exp_fin);
        check(stalls == v.exp_stall, "R9 stall cycles", stalls, v.exp_stall);
        check(v2 == 0, "R2 pulse shape", v2, 0);
        check(v3 == 0, "R3 setup hold", v3, 0);
        check(v4 == 0, "R4 verify mode", v4, 0);
        check(v7 == 0, "R7 bus turnaround", v7, 0);
        check(v8 == 0, "R8 final read order", v8, 0);
        repeat (10) @(negedge clk);
        check(done && pass == v.exp_pass[0], "R10 result held", int'(pass), v.exp_pass);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: idle pin state during reset
        check(mem_ce_n && mem_oe_n && !mem_wdata_oe && !mem_vpp_hi && !busy && !done && !src_req,
              "R1 reset state", int'({mem_ce_n, mem_oe_n, mem_wdata_oe, mem_vpp_hi, busy, done, src_req}),
              7'b1100000);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && mem_ce_n && mem_oe_n, "R1 idle after reset",
              int'({busy, done}), 0);
        for (int i = 0; i < 6; i++) run_vec(i);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule